// File: doc/BRIEF.md
# LCD Scan Timing Generator

This block derives the row and column timing of a passive dot-matrix LCD panel from the oscillator clock. A character slot always spans 8 dots. Each dot takes one shift-clock period, which is two oscillator clocks, so a slot lasts 16 oscillator clocks no matter which font width the pixel path uses. A dot row is a run of character slots. A frame is a run of dot rows. The block emits the column shift clock, a line latch pulse, a row-driver sync pulse and an AC-inversion frame signal. It also exposes its column and dot-row counters to the display-memory fetch logic.

Pins pick the panel geometry from a fixed table: the number of character columns, the number of text lines, and single or dual scan. In dual scan the upper and lower halves are refreshed in parallel. The panel then has twice as many text lines, but each half is scanned with the same number of dot rows as in single scan, and a half-select output tells the fetch logic which half a slot's second fetch belongs to. The geometry pins are sampled only while the block is held in reset or halt.

Reset and halt both freeze the scan in a defined idle state. Reset must be held low for at least 5 oscillator clocks. The DC/DC enable for the panel bias supply follows both inputs, so panel power drops whenever the scan stops. A busy flag covers a short window at the start of every dot row, so the host interface can hold off during the line-end address calculation.

Top module: `lcd_scan_timer`

## Requirements
- R1: `col_sel` = {MD3,MD2} picks 32 (2'b11), 40 (2'b10), 64 (2'b01) or 80 (2'b00) columns. A dot row lasts 16 clocks per column. `col_cnt` counts 0 up to columns−1 and advances every 16 clocks.
- R2: With k = {line_sel[2], ~line_sel[1], ~line_sel[0]}, a frame has 16·(k+1) dot rows (duty 1/16 to 1/128). This holds in both scan modes. `row_cnt` counts 0 up to rows−1 and advances at the end of each dot row.
- R3: `scp` is low on the even clocks of the scan and high on the odd clocks, giving half the oscillator rate.
- R4: `lp` is high for exactly the first two clocks (one shift-clock period) of every dot row, which is the period right after the previous row's last column.
- R5: `cdata` is high together with `lp` only in dot row 0. It is otherwise low while scanning.
- R6: `fr` is high when scanning starts and inverts once per frame, on the clock that wraps from the last row's last slot to row 0.
- R7: `eol_busy` is high for the first BUSY_CLKS clocks (default 10) of every dot row and low otherwise.
- R8: While `rst_n` or `halt_n` is low, `scp`=0, `lp`=0, `cdata`=1, `fr`=1, `eol_busy`=0, `half_sel`=0 and `dcdc_en`=0, all without waiting for a clock. The counters read 0 after the next clock. `dcdc_en` is 1 while both inputs are high.
- R9: The geometry pins are captured only while reset or halt is active. Changes to them during scanning have no effect on timing.
- R10: `scan_single`=0 selects dual scan, in which `half_sel` is high in the last 8 clocks of each slot. With `scan_single`=1, `half_sel` stays 0.
- R11: After halt or reset is released, the scan restarts at row 0, column 0, slot clock 0, with `fr` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Reset, active low |
| halt_n | input | 1 | Halt, active low; stops the scan like reset |
| scan_single | input | 1 | 1 = single scan, 0 = dual scan |
| line_sel | input | 3 | Text-line code {MDS,MD1,MD0} |
| col_sel | input | 2 | Column code {MD3,MD2} |
| scp | output | 1 | Column shift clock |
| lp | output | 1 | Line latch pulse / row shift clock |
| cdata | output | 1 | Row-driver frame sync |
| fr | output | 1 | AC inversion frame signal |
| dcdc_en | output | 1 | External DC/DC enable |
| eol_busy | output | 1 | Line-end busy window for the host side |
| half_sel | output | 1 | Lower-half fetch phase in dual scan |
| col_cnt | output | 7 | Current character column |
| row_cnt | output | 7 | Current dot row within a screen half |

## Verification
The hardest point to reach is the frame wrap. The `fr` inversion and the `cdata` return to row 0 happen only after up to 163,840 clocks, and only one in every 16·columns·rows clocks. The bench therefore runs the smallest geometries through at least one full frame and compares every output on every clock against counters computed from the requirement formulas. The larger line codes are run for a few rows only. The pin-ignore case and the halt case are forced in the middle of running frames: pins flip a few clocks after release, and halt drops a thousand clocks in. After each, the bench checks that the scan restarts from the origin.

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int BUSY_CLKS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_n,
  input  logic       scan_single,
  input  logic [2:0] line_sel,
  input  logic [1:0] col_sel,
  output logic       scp,
  output logic       lp,
  output logic       cdata,
  output logic       fr,
  output logic       dcdc_en,
  output logic       eol_busy,
  output logic       half_sel,
  output logic [6:0] col_cnt,
  output logic [6:0] row_cnt
);
  localparam int DOTS     = 8;
  localparam int SLOT_W   = $clog2(2 * DOTS);
  localparam logic [SLOT_W:0] BUSY_LIM = (SLOT_W + 1)'(BUSY_CLKS);

  logic              act;
  logic [SLOT_W-1:0] sub;
  logic [6:0]        col_q, row_q, col_last, row_last, col_last_d;
  logic              dual_q, fr_q;
  logic [2:0]        kline;
  logic              slot_end, row_end, frame_end, row_start;

  assign act   = rst_n & halt_n;
  assign kline = {line_sel[2], ~line_sel[1], ~line_sel[0]};

  always_comb begin
    case (col_sel)
      2'b11:   col_last_d = 7'd31;
      2'b10:   col_last_d = 7'd39;
      2'b01:   col_last_d = 7'd63;
      default: col_last_d = 7'd79;
    endcase
  end

  assign slot_end  = &sub;
  assign row_end   = slot_end & (col_q == col_last);
  assign frame_end = row_end & (row_q == row_last);

  always_ff @(posedge clk) begin
    if (!act) begin
      sub      <= '0;
      col_q    <= '0;
      row_q    <= '0;
      fr_q     <= 1'b1;
      col_last <= col_last_d;
      row_last <= {kline, 4'hF};
      dual_q   <= ~scan_single;
    end else begin
      sub <= sub + 1'b1;
      if (slot_end) col_q <= row_end ? '0 : col_q + 1'b1;
      if (row_end)  row_q <= frame_end ? '0 : row_q + 1'b1;
      if (frame_end) fr_q <= ~fr_q;
    end
  end

  assign row_start = (col_q == '0);
  assign scp       = act & sub[0];
  assign lp        = act & row_start & (sub[SLOT_W-1:1] == '0);
  assign cdata     = ~act | (lp & (row_q == '0));
  assign fr        = ~act | fr_q;
  assign dcdc_en   = act;
  assign eol_busy  = act & row_start & ({1'b0, sub} < BUSY_LIM);
  assign half_sel  = act & dual_q & sub[SLOT_W-1];
  assign col_cnt   = col_q;
  assign row_cnt   = row_q;

  p_col_bound_r1: assert property (@(posedge clk) disable iff (!act)
    col_q <= col_last);
  p_row_bound_r2: assert property (@(posedge clk) disable iff (!act)
    row_q <= row_last);
  p_lp_width_r4: assert property (@(posedge clk) disable iff (!act)
    $rose(lp) |=> lp);
  p_lp_end_r4: assert property (@(posedge clk) disable iff (!act)
    lp && $past(lp) |=> !lp);
  p_cdata_in_lp_r5: assert property (@(posedge clk) disable iff (!act)
    cdata |-> lp);
  p_fr_at_wrap_r6: assert property (@(posedge clk) disable iff (!act)
    !$stable(fr_q) |-> (row_q == '0 && col_q == '0 && sub == '0));
  p_busy_covers_lp_r7: assert property (@(posedge clk) disable iff (!act)
    lp |-> eol_busy);
  p_halt_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |=> (sub == '0 && col_q == '0 && row_q == '0 && fr_q));
  p_geom_hold_r9: assert property (@(posedge clk) disable iff (!act)
    $past(act) |-> ($stable(col_last) && $stable(row_last) && $stable(dual_q)));
  p_half_single_r10: assert property (@(posedge clk) disable iff (!act)
    !dual_q |-> !half_sel);
endmodule

// File: tb/tb_lcd_scan_timer.sv
module tb_lcd_scan_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0, halt_n = 1'b1, scan_single = 1'b1;
  logic [2:0] line_sel = 3'b011;
  logic [1:0] col_sel = 2'b11;
  logic scp, lp, cdata, fr, dcdc_en, eol_busy, half_sel;
  logic [6:0] col_cnt, row_cnt;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam int BUSY = 10;

  always #4 clk = ~clk;

  lcd_scan_timer #(.BUSY_CLKS(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .scan_single(scan_single),
    .line_sel(line_sel), .col_sel(col_sel), .scp(scp), .lp(lp), .cdata(cdata),
    .fr(fr), .dcdc_en(dcdc_en), .eol_busy(eol_busy), .half_sel(half_sel),
    .col_cnt(col_cnt), .row_cnt(row_cnt));

  task automatic chk(input string tag, input int got, input int exp, input int t);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, got, exp);
    end
  endtask

  task automatic chk_idle(input bool_cnt);
    chk("R8 scp idle", scp, 0, -1);
    chk("R8 lp idle", lp, 0, -1);
    chk("R8 cdata idle", cdata, 1, -1);
    chk("R8 fr idle", fr, 1, -1);
    chk("R8 busy idle", eol_busy, 0, -1);
    chk("R8 half idle", half_sel, 0, -1);
    chk("R8 dcdc off", dcdc_en, 0, -1);
    if (bool_cnt) begin
      chk("R8 col cleared", col_cnt, 0, -1);
      chk("R8 row cleared", row_cnt, 0, -1);
    end
  endtask

  task automatic run_cfg(input logic [1:0] cs, input logic [2:0] ls, input logic single,
                         input int n, input int halt_at, input bit chg);
    int cols, rows, t, sub, col, row, frm;
    bit lpe;
    cols = (cs == 2'b11) ? 32 : (cs == 2'b10) ? 40 : (cs == 2'b01) ? 64 : 80;
    rows = 16 * ({ls[2], ~ls[1], ~ls[0]} + 1);
    @(negedge clk);
    rst_n = 1'b0; halt_n = 1'b1; col_sel = cs; line_sel = ls; scan_single = single;
    repeat (5) @(negedge clk);
    #1 chk_idle(1);
    @(negedge clk);
    rst_n = 1'b1;
    t = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (chg && i == 7) begin
        col_sel = ~cs; line_sel = ~ls; scan_single = ~single;  // R9 stimulus
      end
      if (halt_at > 0 && i == halt_at) begin
        halt_n = 1'b0;
        #1 chk_idle(0);
        repeat (3) @(negedge clk);
        #1 chk_idle(1);
        halt_n = 1'b1;
        t = 0;  // R11 restart origin
      end
      #1;
      sub = t % 16;
      col = (t / 16) % cols;
      row = (t / (16 * cols)) % rows;
      frm = t / (16 * cols * rows);
      lpe = (col == 0) && (sub < 2);
      chk("R1 col_cnt", col_cnt, col, t);
      chk("R2 row_cnt", row_cnt, row, t);
      chk("R3 scp", scp, sub % 2, t);
      chk("R4 lp", lp, lpe, t);
      chk("R5 cdata", cdata, lpe && row == 0, t);
      chk("R6 fr", fr, (frm % 2) == 0, t);
      chk("R7 eol_busy", eol_busy, (col == 0) && (sub < BUSY), t);
      chk("R8 dcdc on", dcdc_en, 1, t);
      chk("R10 half_sel", half_sel, !single && sub >= 8, t);
      t++;
    end
  endtask

  initial begin
    run_cfg(2'b11, 3'b011, 1'b1, 8192 + 40, 0, 0);
    run_cfg(2'b10, 3'b011, 1'b1, 10240 + 40, 0, 0);
    run_cfg(2'b01, 3'b011, 1'b1, 16384 + 40, 0, 0);
    run_cfg(2'b00, 3'b011, 1'b1, 20480 + 40, 0, 0);
    run_cfg(2'b11, 3'b010, 1'b1, 16384 + 40, 0, 0);
    run_cfg(2'b11, 3'b001, 1'b1, 24576 + 40, 0, 0);
    for (int c = 4; c < 8; c++) run_cfg(2'b11, 3'(c), 1'b1, 1600, 0, 0);
    run_cfg(2'b11, 3'b011, 1'b0, 8192 + 40, 0, 1);   // R9, R10 in dual scan
    run_cfg(2'b10, 3'b010, 1'b0, 3000, 1000, 0);     // R8, R11 halt mid-frame
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule